// File: doc/BRIEF.md
# Coprocessor status word with sticky range errors and pause counter

This block is the host-facing status and control point of an arithmetic coprocessor, together with the counter that holds its instruction sequencer in a pause. The host reads a 16-bit status word at a single address. That word carries the remaining pause count, a presence flag, an activity flag and three sticky range-error flags. A write to the same address does not reach the status word. It loads a separate write-only enable register, and that register selects which of the three error flags may drive a shared error line.

The arithmetic datapath reports a negative overflow, a positive overflow or a generic range fault on three event inputs. Each event sets its flag, and the flag stays set until the host reads the status word. The sequencer asks for a pause of d cycles with a load strobe. The stall output then holds execution for exactly d instruction cycles, which matches d+1 empty instructions including the pausing one. Every clock cycle counts as one instruction cycle.

Top module: `coproc_status`

## Requirements
- R1: While reset is asserted and right after it, the count field, the error flags, the enables, `stall` and `err_line` are all 0.
- R2: The status word has the remaining pause count in bits 2:0, `unit_present` in bit 8, `seq_active` in bit 9, the negative-overflow flag in bit 13, the positive-overflow flag in bit 14 and the any-error flag in bit 15. Every other bit reads 0.
- R3: `err_evt[0]` (negative) sets bit 13 and `err_evt[1]` (positive) sets bit 14. Any of the three event inputs, including `err_evt[2]` (generic range fault), sets bit 15. The flag is visible in the cycle after the event.
- R4: An error flag stays set in every cycle without a read. A `host_rd` strobe clears all three flags from the next cycle on, unless a new event occurs in that same cycle.
- R5: An event that arrives in the same cycle as a `host_rd` strobe leaves its flag set after the read.
- R6: A `host_wr` strobe stores `host_wdata[15:13]` as the enables for the any, positive and negative flags. Bit 15 enables the any flag, bit 14 the positive flag and bit 13 the negative flag. The write leaves the status word unchanged.
- R7: `err_line` is high exactly when some error flag and its enable bit are both set.
- R8: After `pause_load` with length d > 0, `stall` is high for exactly d cycles, starting in the cycle after the load. The count field steps down by one each cycle.
- R9: A `pause_load` with length 0 causes no stall.
- R10: A `pause_load` during a running pause restarts the count at the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Status read strobe; clears the error flags |
| host_wr | input | 1 | Enable register write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Status word |
| unit_present | input | 1 | Presence flag reported in the status word |
| seq_active | input | 1 | Activity flag reported in the status word |
| err_evt | input | 3 | Error events: [0] negative, [1] positive, [2] generic |
| pause_load | input | 1 | Starts a pause of `pause_len` cycles |
| pause_len | input | 3 | Pause length d |
| stall | output | 1 | Holds the instruction sequencer |
| err_line | output | 1 | Enabled error flags ORed together |

## Verification
A flag lost or cleared at the wrong time shows in the top three bits of `host_rdata` one cycle after the event or the read. The most telling cases are an event that coincides with a read and a flag that must survive idle cycles. A bad enable register shows on `err_line` in the cycle after the write, provided a flag is set. Set flags are therefore kept in place while the enables change. A counter that is off by one shows in the low bits of the status word and in `stall` within one cycle of the load, and it reaches its sharpest test when a reload lands mid-pause.

// File: rtl/coproc_status_pkg.sv
`timescale 1ns/1ps
package coproc_status_pkg;
  localparam int WORD_W      = 16;
  localparam int PAUSE_W     = 3;
  localparam int NUM_ERR     = 3;
  localparam int PRESENT_BIT = 8;
  localparam int ACTIVE_BIT  = 9;
  localparam int ERR_LSB     = 13;
  localparam int ERR_NEG     = 0;
  localparam int ERR_POS     = 1;
  localparam int ERR_ANY     = 2;

  typedef logic [NUM_ERR-1:0] err_vec_t;

  // Maps raw events to flag set requests: the any flag collects all three.
  function automatic err_vec_t err_capture(input logic [NUM_ERR-1:0] evt);
    err_vec_t s;
    s          = '0;
    s[ERR_NEG] = evt[0];
    s[ERR_POS] = evt[1];
    s[ERR_ANY] = |evt;
    return s;
  endfunction

  // Places the status fields; untouched bits stay 0.
  function automatic logic [WORD_W-1:0] pack_status(
      input logic [PAUSE_W-1:0] cnt, input logic pres,
      input logic act, input err_vec_t err);
    logic [WORD_W-1:0] w;
    w                             = '0;
    w[PAUSE_W-1:0]                = cnt;
    w[PRESENT_BIT]                = pres;
    w[ACTIVE_BIT]                 = act;
    w[ERR_LSB+NUM_ERR-1:ERR_LSB]  = err;
    return w;
  endfunction

  // Error line: any flag whose enable is set.
  function automatic logic err_gate(input err_vec_t flags, input err_vec_t en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/err_sticky.sv
`timescale 1ns/1ps
module err_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  // One flop per flag; a set in the clear cycle wins.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end
  end

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R5
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(set)) == $past(set)));
  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (flags == '0));
endmodule

// File: rtl/pause_ctr.sv
`timescale 1ns/1ps
module pause_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         stall
);
  logic cnt_busy;
  assign cnt_busy = (cnt != '0);
  assign stall    = cnt_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= len;
    else if (cnt_busy) cnt <= cnt - 1'b1;
  end

  // R8
  pause_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == W'($past(cnt) - 1'b1)));
  // R10
  pause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(len)));
  // R9
  pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> !stall);
endmodule

// File: rtl/coproc_status.sv
`timescale 1ns/1ps
module coproc_status
  import coproc_status_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int PW = PAUSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          unit_present,
  input  logic          seq_active,
  input  logic [2:0]    err_evt,
  input  logic          pause_load,
  input  logic [PW-1:0] pause_len,
  output logic          stall,
  output logic          err_line
);
  localparam int EN_MSB = ERR_LSB + NUM_ERR - 1;

  err_vec_t        err_set;
  err_vec_t        err_flags;
  err_vec_t        err_en;
  logic [PW-1:0]   pause_cnt;
  wire             unused_wbits = ^{host_wdata[ERR_LSB-1:0]};

  assign err_set = err_capture(err_evt);

  err_sticky #(.N(NUM_ERR)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (host_rd),
    .set   (err_set),
    .flags (err_flags)
  );

  pause_ctr #(.W(PW)) u_pause (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pause_load),
    .len   (pause_len),
    .cnt   (pause_cnt),
    .stall (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_en <= '0;
    else if (host_wr) err_en <= host_wdata[EN_MSB:ERR_LSB];
  end

  assign host_rdata = pack_status(pause_cnt, unit_present, seq_active, err_flags);
  assign err_line   = err_gate(err_flags, err_en);

  // R6
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (err_en == $past(host_wdata[EN_MSB:ERR_LSB])));
  // R7
  line_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en == '0) |-> !err_line);
  // R3
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> host_rdata[ERR_LSB+ERR_ANY]);
endmodule

// File: tb/coproc_status_tb.sv
`timescale 1ns/1ps
module coproc_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        unit_present = 1'b1, seq_active = 1'b0;
  logic [2:0]  err_evt = '0;
  logic        pause_load = 1'b0;
  logic [2:0]  pause_len = '0;
  logic        stall, err_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  coproc_status u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .unit_present(unit_present), .seq_active(seq_active),
    .err_evt(err_evt), .pause_load(pause_load), .pause_len(pause_len),
    .stall(stall), .err_line(err_line)
  );

  always #10 clk = ~clk;

  // Reference state, written from the requirements.
  logic [2:0] m_cnt = '0;
  logic [2:0] m_err = '0;   // [2]=any [1]=pos [0]=neg
  logic [2:0] m_en  = '0;

  typedef struct {
    logic [2:0] cnt;
    logic [2:0] err;
    logic [2:0] en;
    string      tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [15:0] want_word(exp_t e);
    return {e.err, 3'b000, seq_active, unit_present, 5'b00000, e.cnt};
  endfunction

  task automatic report(bit ok, string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: compares one queued expectation per falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [15:0] w;
      e = sb.pop_front();
      w = want_word(e);
      report(host_rdata == w && stall == (e.cnt != 0) &&
             err_line == |(e.err & e.en), e.tag,
             {host_rdata[15:2], stall, err_line},
             {w[15:2], (e.cnt != 0), |(e.err & e.en)});
    end
  end

  // Driver: one clock with the inputs currently set, then model update.
  task automatic tick(string tag);
    exp_t e;
    @(posedge clk);
    if (pause_load)      m_cnt = pause_len;
    else if (m_cnt != 0) m_cnt = m_cnt - 3'd1;
    m_err = (host_rd ? 3'b000 : m_err) | {|err_evt, err_evt[1], err_evt[0]};
    if (host_wr) m_en = host_wdata[15:13];
    #1;
    host_rd = 1'b0; host_wr = 1'b0; err_evt = '0; pause_load = 1'b0;
    e.cnt = m_cnt; e.err = m_err; e.en = m_en; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    report(host_rdata == 16'h0100 && !stall && !err_line, "R1 reset",
           host_rdata, 16'h0100);
    rst_n = 1'b1;
    @(negedge clk);
    report(host_rdata == 16'h0100 && !stall && !err_line, "R1 after reset",
           host_rdata, 16'h0100);
    @(posedge clk); #1;

    // R2: field placement
    seq_active = 1'b1;   tick("R2 active");
    unit_present = 1'b0; tick("R2 present low");
    unit_present = 1'b1; seq_active = 1'b0; tick("R2 idle");

    // R3: each event source
    err_evt = 3'b001; tick("R3 negative");
    host_rd = 1'b1;   tick("R4 clear");
    err_evt = 3'b010; tick("R3 positive");
    host_rd = 1'b1;   tick("R4 clear");
    err_evt = 3'b100; tick("R3 generic");
    host_rd = 1'b1;   tick("R4 clear");

    // R4: hold across idle cycles, then read
    err_evt = 3'b001; tick("R4 set");
    tick("R4 hold"); tick("R4 hold");
    host_rd = 1'b1;   tick("R4 read clears");

    // R5: event coinciding with read
    err_evt = 3'b010; tick("R5 set");
    host_rd = 1'b1; err_evt = 3'b001; tick("R5 read with event");
    tick("R5 hold");
    host_rd = 1'b1; tick("R5 clear");

    // R6/R7: enables
    host_wr = 1'b1; host_wdata = 16'hFFFF; tick("R6 write no effect");
    err_evt = 3'b001; tick("R7 all enabled");
    host_rd = 1'b1;   tick("R7 cleared");
    host_wr = 1'b1; host_wdata = 16'h2000; tick("R6 neg only");
    err_evt = 3'b010; tick("R7 masked");
    err_evt = 3'b001; tick("R7 neg enabled");
    host_wr = 1'b1; host_wdata = 16'h4000; tick("R6 pos only flags kept");
    host_wr = 1'b1; host_wdata = 16'h1FFF; tick("R7 all disabled");
    host_wr = 1'b1; host_wdata = 16'h8000; tick("R7 any enabled");
    host_rd = 1'b1; tick("R7 read drops line");

    // R8: pause of 5
    pause_len = 3'd5; pause_load = 1'b1; tick("R8 load");
    for (int i = 0; i < 6; i++) tick("R8 countdown");

    // R9: zero-length pause
    pause_len = 3'd0; pause_load = 1'b1; tick("R9 zero");
    tick("R9 idle");

    // R10: reload mid-pause
    pause_len = 3'd7; pause_load = 1'b1; tick("R10 first load");
    tick("R10 run"); tick("R10 run");
    pause_len = 3'd2; pause_load = 1'b1; tick("R10 reload");
    for (int i = 0; i < 3; i++) tick("R10 after reload");

    @(negedge clk); #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule